// File: doc/BRIEF.md
# SPI Controller Register Front-End

This block is the register file that sits between a processor bus and the shift engine of an SPI controller. It holds seven 16-bit registers: control, flag, baud, status, transmit buffer, receive buffer and shadow. A write cycle presents an address, a data word and an access size. Only 16-bit accesses to a mapped, word-aligned offset update a register. Any other width, or a 16-bit access to an offset with no register behind it, is dropped and answered with a one-cycle error pulse. The size check takes priority over the address check. All register contents are driven out continuously for the shift engine to use.

The status register mixes three kinds of bit:
- **Engine-owned flags.** Transfer-finished (bit 0), TX-full (bit 3) and RX-full (bit 5) cannot be written from the bus.
- **Sticky error flags.** All other bits are set by hardware pulses on `err_set` and cleared by writing a one to them.
- **Core-initiated mode.** When control bit 14 (enable) is 1 and control bits [1:0] equal 01 (start a transfer on a transmit-buffer write), a write to the transmit buffer sets RX-full and clears TX-full in the same cycle that stores the data.

Register offsets, in bytes: control 0x00, flag 0x04, baud 0x08, status 0x0C, transmit buffer 0x10, receive buffer 0x14, shadow 0x18. Any other offset is unmapped, including offsets that are not a multiple of 4 and all offsets of 0x1C and above. Size codes: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit, 11 is reserved.

Top module: `spi_reg_front`

## Requirements
- R1: After reset, every register reads 0x0000 except status, which reads 0x0001 (transfer-finished set), and `bus_err` is 0.
- R2: A write of size 01 to control, flag, baud, transmit buffer, receive buffer or shadow stores `wr_data[15:0]` into that register. The new value is visible from the clock edge that samples the write.
- R3: A write whose size is not 01 (00, 10 or 11) changes no register and raises `bus_err` for exactly the cycle after the write. This holds whether or not the address is mapped.
- R4: A write of size 01 to an unmapped offset changes no register and raises `bus_err` for the cycle after the write. Unmapped means bits [1:0] are not 00, or the offset is 0x1C or above.
- R5: A status write clears every sticky bit (all bits except 0, 3 and 5) whose data bit is 1, and leaves sticky bits written with 0 unchanged.
- R6: Status bits 0, 3 and 5 keep their value across a status write, whatever the written data.
- R7: A 1 on `err_set[i]` sets status bit i on the next edge for every sticky bit i. `err_set` bits 0, 3 and 5 have no effect.
- R8: When a sticky bit receives an `err_set` pulse and a write-one-to-clear in the same cycle, the bit ends up set.
- R9: A transmit-buffer write while control bit 14 is 1 and control bits [1:0] are 01 sets status bit 5 (RX-full) and clears status bit 3 (TX-full).
- R10: A transmit-buffer write with control bit 14 at 0, or with control bits [1:0] other than 01, stores the data and leaves status bits 3 and 5 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_size | input | 2 | Access size: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit |
| wr_data | input | 32 | Write data; bits [15:0] are used |
| err_set | input | 16 | Hardware set pulses for the sticky status bits |
| bus_err | output | 1 | One-cycle error pulse for a rejected write |
| ctl | output | 16 | Control register |
| flg | output | 16 | Flag register |
| baud | output | 16 | Baud register |
| stat | output | 16 | Status register |
| tdbr | output | 16 | Transmit buffer register |
| rdbr | output | 16 | Receive buffer register |
| shadow | output | 16 | Shadow register |

## Verification
Every result of this block is due one clock edge after the stimulus:
- A write, an `err_set` pulse or a rejected access is sampled on a rising edge.
- The updated register value or the `bus_err` pulse is present from that edge until the next one.

The bench drives each stimulus on a falling edge and holds it through one rising edge. At the following falling edge it drops the stimulus and compares all eight outputs against its own model, advanced once for that edge. An idle cycle follows each step, so a pulse that lasts too long, or a change that arrives late, shows up in the next comparison.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int REG_W = 16;
  localparam int NREG  = 7;

  typedef enum logic [2:0] {
    IX_CTL, IX_FLG, IX_BAUD, IX_STAT, IX_TDBR, IX_RDBR, IX_SHADOW
  } reg_ix_e;

  localparam int BIT_DONE = 0;
  localparam int BIT_TXF  = 3;
  localparam int BIT_RXF  = 5;
  localparam int BIT_EN   = 14;
  localparam logic [1:0] MODE_CORE = 2'b01;
  localparam logic [1:0] SZ_HALF   = 2'b01;

  localparam logic [REG_W-1:0] FIXED_MASK =
    REG_W'((1 << BIT_DONE) | (1 << BIT_TXF) | (1 << BIT_RXF));
  localparam logic [REG_W-1:0] STICKY_MASK = ~FIXED_MASK;
  localparam logic [REG_W-1:0] STAT_RST = REG_W'(1 << BIT_DONE);

  // Next status value: write-one-to-clear first, then core-mode flags, then hw set (set wins).
  function automatic logic [REG_W-1:0] stat_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] wdat,
    input logic             w1c,
    input logic [REG_W-1:0] hwset,
    input logic             core_evt);
    logic [REG_W-1:0] n;
    n = cur & ~(w1c ? (wdat & STICKY_MASK) : '0);
    if (core_evt) begin
      n[BIT_RXF] = 1'b1;
      n[BIT_TXF] = 1'b0;
    end
    n = n | (hwset & STICKY_MASK);
    return n;
  endfunction

  function automatic logic core_start(input logic [REG_W-1:0] c);
    return c[BIT_EN] && (c[1:0] == MODE_CORE);
  endfunction
endpackage

// File: rtl/spi_reg_decode.sv
module spi_reg_decode
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  output logic [NREG-1:0]   sel,
  output logic              acc_err
);
  localparam int IXW = ADDR_W - 2;

  logic            size_bad;
  logic            addr_miss;
  logic [IXW-1:0]  ix;

  assign ix        = wr_addr[ADDR_W-1:2];
  assign size_bad  = (wr_size != SZ_HALF);
  assign addr_miss = (wr_addr[1:0] != 2'b00) || (ix >= IXW'(NREG));
  assign acc_err   = wr_en && (size_bad || addr_miss);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = wr_en && !size_bad && !addr_miss && (ix == IXW'(i));
  end

  // R3: a bad width never selects a register, mapped or not
  p_width_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_bad) |-> (acc_err && (sel == '0)));
  // R4: halfword to a hole selects nothing and errors
  p_hole_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !size_bad && addr_miss) |-> (acc_err && (sel == '0)));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regs_pkg::*;
#(
  parameter int SKIP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            sel,
  input  logic [REG_W-1:0]           wdata,
  output logic [NREG-1:0][REG_W-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == SKIP) begin : g_hole
      assign q[i] = '0;
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q[i] <= '0;
        else if (sel[i]) q[i] <= wdata;
      end
    end
  end

  // R3/R4: without a selected register the plain bank holds
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> $stable(q));
endmodule

// File: rtl/spi_reg_status.sv
module spi_reg_status
  import spi_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w1c_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] hw_set,
  input  logic             core_evt,
  output logic [REG_W-1:0] stat_q
);
  logic [REG_W-1:0] stat_d;
  logic [REG_W-1:0] clr_req;

  assign clr_req = w1c_we ? (wdata & STICKY_MASK) : '0;
  assign stat_d  = stat_next(stat_q, wdata, w1c_we, hw_set, core_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  // R5: requested clears without a competing set take effect
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & ~hw_set)) |=> ((stat_q & $past(clr_req & ~hw_set)) == '0));
  // R6: engine-owned flags ignore a status write
  p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_we && !core_evt) |=> ((stat_q & FIXED_MASK) == ($past(stat_q) & FIXED_MASK)));
  // R7 / R8: a hw set always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & STICKY_MASK)) |=>
      ((stat_q & $past(hw_set & STICKY_MASK)) == $past(hw_set & STICKY_MASK)));
  // R9: core-mode transmit write flips the buffer flags
  p_core_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_evt |=> (stat_q[BIT_RXF] && !stat_q[BIT_TXF]));
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  err_set,
  output logic              bus_err,
  output logic [REG_W-1:0]  ctl,
  output logic [REG_W-1:0]  flg,
  output logic [REG_W-1:0]  baud,
  output logic [REG_W-1:0]  stat,
  output logic [REG_W-1:0]  tdbr,
  output logic [REG_W-1:0]  rdbr,
  output logic [REG_W-1:0]  shadow
);
  logic [NREG-1:0]            sel;
  logic                       acc_err;
  logic [NREG-1:0][REG_W-1:0] bank_q;
  logic [REG_W-1:0]           wdat16;
  logic                       tdbr_core_evt;
  logic                       err_q;

  assign wdat16 = wr_data[REG_W-1:0];

  spi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .sel(sel), .acc_err(acc_err));

  spi_reg_bank #(.SKIP(int'(IX_STAT))) u_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdat16), .q(bank_q));

  assign tdbr_core_evt = sel[IX_TDBR] && core_start(bank_q[IX_CTL]);

  spi_reg_status u_stat (
    .clk(clk), .rst_n(rst_n), .w1c_we(sel[IX_STAT]), .wdata(wdat16),
    .hw_set(err_set), .core_evt(tdbr_core_evt), .stat_q(stat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= acc_err;
  end

  assign bus_err = err_q;
  assign ctl     = bank_q[IX_CTL];
  assign flg     = bank_q[IX_FLG];
  assign baud    = bank_q[IX_BAUD];
  assign tdbr    = bank_q[IX_TDBR];
  assign rdbr    = bank_q[IX_RDBR];
  assign shadow  = bank_q[IX_SHADOW];

  // R3: wrong width pulses the error and leaves control alone
  p_width_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size != SZ_HALF) |=> (bus_err && $stable(ctl)));
  // R4: halfword beyond the map pulses the error
  p_hole_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_HALF && wr_addr >= ADDR_W'(NREG * 4)) |=> bus_err);
  // R2: an accepted halfword never raises the error
  p_no_err_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_HALF && wr_addr[1:0] == 2'b00 &&
     wr_addr < ADDR_W'(NREG * 4)) |=> !bus_err);
endmodule

// File: tb/spi_reg_front_test.sv
module spi_reg_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] err_set = '0;
  logic        bus_err;
  logic [15:0] ctl, flg, baud, stat, tdbr, rdbr, shadow;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_ctl, m_flg, m_baud, m_stat, m_tdbr, m_rdbr, m_shadow;
  logic        m_err;

  always #2.5 clk = ~clk;

  spi_reg_front uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .err_set(err_set),
    .bus_err(bus_err), .ctl(ctl), .flg(flg), .baud(baud), .stat(stat),
    .tdbr(tdbr), .rdbr(rdbr), .shadow(shadow));

  function automatic logic [15:0] sticky(input logic [15:0] v);
    return v & 16'hFFD6;
  endfunction

  task automatic model_reset();
    m_ctl = 0; m_flg = 0; m_baud = 0; m_tdbr = 0; m_rdbr = 0; m_shadow = 0;
    m_stat = 16'h0001; m_err = 0;
  endtask

  task automatic model_edge(input logic we, input logic [7:0] a,
                            input logic [1:0] sz, input logic [15:0] d,
                            input logic [15:0] hs);
    logic ok;
    ok = we && sz == 2'b01 && a[1:0] == 2'b00 && a < 8'h1C;
    m_err = we && !ok;
    if (ok) begin
      case (a)
        8'h00: m_ctl = d;
        8'h04: m_flg = d;
        8'h08: m_baud = d;
        8'h0C: m_stat = m_stat & ~sticky(d);
        8'h10: begin
          m_tdbr = d;
          if (m_ctl[14] && m_ctl[1:0] == 2'b01) begin
            m_stat[5] = 1'b1;
            m_stat[3] = 1'b0;
          end
        end
        8'h14: m_rdbr = d;
        default: m_shadow = d;
      endcase
    end
    m_stat = m_stat | sticky(hs);
  endtask

  task automatic chk(input string tag, input string nm,
                     input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "bus_err", {15'd0, bus_err}, {15'd0, m_err});
    chk(tag, "ctl", ctl, m_ctl);
    chk(tag, "flg", flg, m_flg);
    chk(tag, "baud", baud, m_baud);
    chk(tag, "stat", stat, m_stat);
    chk(tag, "tdbr", tdbr, m_tdbr);
    chk(tag, "rdbr", rdbr, m_rdbr);
    chk(tag, "shadow", shadow, m_shadow);
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [15:0] hs, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_size = sz; wr_data = d; err_set = hs;
    @(posedge clk);
    model_edge(we, a, sz, d[15:0], hs);
    @(negedge clk);
    wr_en = 1'b0; err_set = '0;
    compare_all(tag);
    m_err = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    step(1, 8'h00, 2'b01, 32'h0000_1234, 0, "R2 ctl");
    step(1, 8'h18, 2'b01, 32'hFFFF_BEEF, 0, "R2 shadow");
    step(1, 8'h00, 2'b00, 32'h0000_5555, 0, "R3 byte");
    step(1, 8'h04, 2'b10, 32'h0000_5555, 0, "R3 word");
    step(1, 8'h20, 2'b11, 32'h0000_5555, 0, "R3 bad size unmapped");
    step(1, 8'h1C, 2'b01, 32'h0000_7777, 0, "R4 past end");
    step(1, 8'h02, 2'b01, 32'h0000_7777, 0, "R4 misaligned");
    step(1, 8'h00, 2'b01, 32'h0000_0001, 0, "R10 ctl mode no enable");
    step(1, 8'h10, 2'b01, 32'h0000_00A5, 0, "R10 tdbr disabled");
    step(1, 8'h00, 2'b01, 32'h0000_4002, 0, "R10 ctl other mode");
    step(1, 8'h10, 2'b01, 32'h0000_005A, 0, "R10 tdbr other mode");
    step(0, 8'h00, 2'b01, 0, 16'hFFFF, "R7 hw set all");
    step(1, 8'h0C, 2'b01, 32'h0000_00F0, 0, "R5 partial clear");
    step(1, 8'h00, 2'b01, 32'h0000_4001, 0, "R2 ctl core mode");
    step(1, 8'h10, 2'b01, 32'h0000_ABCD, 0, "R9 core tdbr");
    step(1, 8'h0C, 2'b01, 32'h0000_FFFF, 0, "R6 fixed bits kept");
    step(1, 8'h0C, 2'b01, 32'h0000_0006, 16'h0002, "R8 set beats clear");

    for (int i = 0; i < 2000; i++) begin
      logic [7:0]  a;
      logic [1:0]  sz;
      logic [15:0] hs;
      a  = ($urandom % 8 == 0) ? 8'($urandom % 48) : 8'(($urandom % 7) * 4);
      sz = ($urandom % 6 == 0) ? 2'($urandom) : 2'b01;
      hs = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0000;
      step(1'($urandom % 4 != 0), a, sz, $urandom, hs, "R2/R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule